// File: doc/BRIEF.md
# Gated Clock Fanout with Dual-Personality Outputs

This block copies a single reference clock onto twelve output pairs and one feedback line. Each pair has a true leg and a complement leg. A mode input chooses how the complement legs behave. In the all-DDR arrangement, every complement leg carries the inverted reference. In the mixed arrangement, the lower six pairs become SDR clock lines: both of their legs run in phase with the reference. The upper six pairs keep the inverted complement.

Each pair has its own enable bit, and both legs of the pair obey it. The enable passes through a latch-based clock gate that is transparent only while the reference is low. A change made during a high phase therefore waits for the next falling edge, and no shortened pulse can appear.

A disabled pair parks at static levels and does not float. An active-low power-down input removes the drive from every output, including the feedback line. Power-down also presets all gates to enabled. Two drive-boost inputs are routed to each pair according to whether that pair currently acts as an SDR or a DDR output.

Top module: `ckfan_buffer`

## Requirements
- R1: While `pd_n` is 1, `fb_clk` equals `ref_clk` whatever `pair_en` holds, and `fb_oe` is 1.
- R2: While `pd_n` is 0, every bit of `pair_oe` and `fb_oe` is 0. While `pd_n` is 1, every bit of `pair_oe` is 1.
- R3: With `ddr_only` = 1, every enabled pair drives `pair_t[i]` = `ref_clk` and `pair_c[i]` = NOT `ref_clk`.
- R4: With `ddr_only` = 0, pairs 0 to 5 drive `pair_c[i]` equal to `pair_t[i]`, both in phase with `ref_clk`. Pairs 6 to 11 keep `pair_c[i]` = NOT `pair_t[i]`.
- R5: A disabled pair holds `pair_t[i]` at 0. Its `pair_c[i]` is 0 if the pair is in SDR use and 1 if it is in DDR use.
- R6: Bit i of `pair_en` (1 = enabled) controls pair i and no other pair.
- R7: An enable change made while `ref_clk` is high does not alter the outputs until `ref_clk` falls. No true leg is ever high while `ref_clk` is low.
- R8: While `pd_n` is 0, every pair gate is preset to enabled. After release, all pairs run until the first low phase of `ref_clk` loads `pair_en`.
- R9: `pair_boost[i]` equals `sdr_boost` when pair i is in SDR use (`ddr_only` = 0 and i < 6), and `ddr_boost` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock to be distributed |
| ddr_only | input | 1 | 1 = all pairs DDR; 0 = pairs 0..5 SDR, 6..11 DDR |
| pd_n | input | 1 | Active-low power-down; low releases all output drive |
| pair_en | input | 12 | Per-pair enable, bit i for pair i |
| sdr_boost | input | 1 | Drive boost request for pairs in SDR use |
| ddr_boost | input | 1 | Drive boost request for pairs in DDR use |
| pair_t | output | 12 | True leg of each pair |
| pair_c | output | 12 | Complement leg of each pair |
| pair_oe | output | 12 | Output drive enable per pair |
| pair_boost | output | 12 | Boost request routed to each pair |
| fb_clk | output | 1 | Ungated feedback copy of the reference |
| fb_oe | output | 1 | Output drive enable of the feedback line |

## Verification
The assertions check these properties on every reference edge:
- the phase relation between the two legs in each mode (R3, R4);
- that true legs stay quiet while the reference is low (R7);
- feedback liveness and drive (R1);
- the tri-state behaviour under power-down (R2);
- the routing of the boost bits (R9).

Other behaviours depend on history and only the bench scenarios can show them: the one-cycle postponement of an enable change made during a high phase, the all-enabled preset seen right after power-down is released, and the exact per-bit mapping of the enable vector over all 4096 patterns in both modes.

// File: rtl/ckfan_pkg.sv
`timescale 1ns/1ps
package ckfan_pkg;

    // Default geometry: twelve pairs, the lowest six may be SDR.
    localparam int unsigned PAIRS_DEF     = 12;
    localparam int unsigned SDR_PAIRS_DEF = 6;

    // Role a pair plays for the current mode.
    typedef enum logic {
        LEG_SDR = 1'b0,
        LEG_DDR = 1'b1
    } leg_kind_e;

    // A pair is in SDR use only in the mixed mode and only in the lower group.
    function automatic leg_kind_e pair_kind(int unsigned idx,
                                            int unsigned sdr_pairs,
                                            logic        ddr_only);
        return (!ddr_only && (idx < sdr_pairs)) ? LEG_SDR : LEG_DDR;
    endfunction

endpackage

// File: rtl/ckfan_gate.sv
`timescale 1ns/1ps
// Latch-based clock gate. The enable is sampled only while the clock is low.
// Power-down presets the latch to enabled.
module ckfan_gate (
    input  logic clk,
    input  logic pd_n,
    input  logic en,
    output logic gclk
);

    logic en_q;

    always_latch begin
        if (!pd_n) begin
            en_q <= 1'b1;
        end else if (!clk) begin
            en_q <= en;
        end
    end

    assign gclk = clk & en_q;

endmodule

// File: rtl/ckfan_pair.sv
`timescale 1ns/1ps
// One output pair: gate, leg shaping for the current role, boost routing.
module ckfan_pair
    import ckfan_pkg::*;
#(
    parameter int unsigned IDX       = 0,
    parameter int unsigned SDR_PAIRS = SDR_PAIRS_DEF
) (
    input  logic ref_clk,
    input  logic pd_n,
    input  logic en,
    input  logic ddr_only,
    input  logic sdr_boost,
    input  logic ddr_boost,
    output logic leg_t,
    output logic leg_c,
    output logic oe,
    output logic boost
);

    logic      gclk;
    leg_kind_e kind;

    ckfan_gate u_gate (
        .clk  (ref_clk),
        .pd_n (pd_n),
        .en   (en),
        .gclk (gclk)
    );

    assign kind = pair_kind(IDX, SDR_PAIRS, ddr_only);

    always_comb begin
        leg_t = gclk;
        unique case (kind)
            LEG_SDR: begin
                leg_c = gclk;
                boost = sdr_boost;
            end
            LEG_DDR: begin
                leg_c = ~gclk;
                boost = ddr_boost;
            end
            default: begin
                leg_c = ~gclk;
                boost = ddr_boost;
            end
        endcase
    end

    assign oe = pd_n;

endmodule

// File: rtl/ckfan_buffer.sv
`timescale 1ns/1ps
// Top: twelve gated pairs plus an ungated feedback copy.
module ckfan_buffer
    import ckfan_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = PAIRS_DEF,
    parameter int unsigned SDR_PAIRS = SDR_PAIRS_DEF
) (
    input  logic                 ref_clk,
    input  logic                 ddr_only,
    input  logic                 pd_n,
    input  logic [NUM_PAIRS-1:0] pair_en,
    input  logic                 sdr_boost,
    input  logic                 ddr_boost,
    output logic [NUM_PAIRS-1:0] pair_t,
    output logic [NUM_PAIRS-1:0] pair_c,
    output logic [NUM_PAIRS-1:0] pair_oe,
    output logic [NUM_PAIRS-1:0] pair_boost,
    output logic                 fb_clk,
    output logic                 fb_oe
);

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        ckfan_pair #(
            .IDX       (i),
            .SDR_PAIRS (SDR_PAIRS)
        ) u_pair (
            .ref_clk   (ref_clk),
            .pd_n      (pd_n),
            .en        (pair_en[i]),
            .ddr_only  (ddr_only),
            .sdr_boost (sdr_boost),
            .ddr_boost (ddr_boost),
            .leg_t     (pair_t[i]),
            .leg_c     (pair_c[i]),
            .oe        (pair_oe[i]),
            .boost     (pair_boost[i])
        );
    end

    // Feedback is never gated by the enable bits, only by power-down.
    assign fb_clk = ref_clk;
    assign fb_oe  = pd_n;

endmodule

// File: rtl/ckfan_buffer_chk.sv
`timescale 1ns/1ps
module ckfan_buffer_chk #(
    parameter int unsigned NUM_PAIRS = 12,
    parameter int unsigned SDR_PAIRS = 6
) (
    input logic                 ref_clk,
    input logic                 ddr_only,
    input logic                 pd_n,
    input logic                 sdr_boost,
    input logic                 ddr_boost,
    input logic [NUM_PAIRS-1:0] pair_t,
    input logic [NUM_PAIRS-1:0] pair_c,
    input logic [NUM_PAIRS-1:0] pair_oe,
    input logic [NUM_PAIRS-1:0] pair_boost,
    input logic                 fb_clk,
    input logic                 fb_oe
);

    localparam logic [NUM_PAIRS-1:0] LOW_GROUP = NUM_PAIRS'((1 << SDR_PAIRS) - 1);

    logic [NUM_PAIRS-1:0] sdr_mask;
    assign sdr_mask = ddr_only ? '0 : LOW_GROUP;

    always @(posedge ref_clk) begin
        if (pd_n === 1'b0) begin
            AST_PD_HIZ: assert (pair_oe == '0 && fb_oe == 1'b0); // R2
        end
    end

    AST_DRIVE_ON: assert property (@(posedge ref_clk) disable iff (!pd_n) ((&pair_oe) && fb_oe)); // R2

    AST_NO_RUNT: assert property (@(posedge ref_clk) disable iff (!pd_n) (pair_t == '0)); // R7

    AST_FB_LIVE: assert property (@(negedge ref_clk) disable iff (!pd_n) (fb_clk && fb_oe)); // R1

    AST_LEG_PHASE_HI: assert property (@(negedge ref_clk) disable iff (!pd_n)
        (pair_c == ((pair_t & sdr_mask) | (~pair_t & ~sdr_mask)))); // R4

    AST_LEG_PHASE_LO: assert property (@(posedge ref_clk) disable iff (!pd_n)
        (pair_c == ~sdr_mask)); // R5

    AST_BOOST_ROUTE: assert property (@(negedge ref_clk) disable iff (!pd_n)
        (pair_boost == (({NUM_PAIRS{sdr_boost}} & sdr_mask) | ({NUM_PAIRS{ddr_boost}} & ~sdr_mask)))); // R9

endmodule

bind ckfan_buffer ckfan_buffer_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .SDR_PAIRS (SDR_PAIRS)
) u_chk (
    .ref_clk    (ref_clk),
    .ddr_only   (ddr_only),
    .pd_n       (pd_n),
    .sdr_boost  (sdr_boost),
    .ddr_boost  (ddr_boost),
    .pair_t     (pair_t),
    .pair_c     (pair_c),
    .pair_oe    (pair_oe),
    .pair_boost (pair_boost),
    .fb_clk     (fb_clk),
    .fb_oe      (fb_oe)
);

// File: tb/ckfan_buffer_test.sv
`timescale 1ns/1ps
module ckfan_buffer_test;

    logic        clk;
    logic        ddr_only;
    logic        pd_n;
    logic [11:0] pair_en;
    logic        sdr_boost;
    logic        ddr_boost;
    logic [11:0] pair_t;
    logic [11:0] pair_c;
    logic [11:0] pair_oe;
    logic [11:0] pair_boost;
    logic        fb_clk;
    logic        fb_oe;

    int checks;
    int errors;

    ckfan_buffer uut (
        .ref_clk    (clk),
        .ddr_only   (ddr_only),
        .pd_n       (pd_n),
        .pair_en    (pair_en),
        .sdr_boost  (sdr_boost),
        .ddr_boost  (ddr_boost),
        .pair_t     (pair_t),
        .pair_c     (pair_c),
        .pair_oe    (pair_oe),
        .pair_boost (pair_boost),
        .fb_clk     (fb_clk),
        .fb_oe      (fb_oe)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic to_low();
        @(negedge clk);
        #2;
    endtask

    task automatic to_high();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=%0t expected=done", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        checks    = 0;
        errors    = 0;
        pd_n      = 1'b0;
        ddr_only  = 1'b1;
        pair_en   = 12'h000;
        sdr_boost = 1'b0;
        ddr_boost = 1'b0;

        // R2: power-down state, every driver released
        to_high();
        chk("R2 pair_oe in power-down", pair_oe, 12'h000);
        chk("R2 fb_oe in power-down", {11'd0, fb_oe}, 12'h000);

        // R8: release during a high phase with all enables at 0
        pd_n = 1'b1;
        #1;
        chk("R8 preset enabled after release", pair_t, 12'hFFF);
        chk("R2 pair_oe after release", pair_oe, 12'hFFF);
        chk("R1 fb_oe after release", {11'd0, fb_oe}, 12'h001);
        to_low();
        chk("R5 disabled true legs", pair_t, 12'h000);
        chk("R5 disabled DDR complements", pair_c, 12'hFFF);
        to_high();
        chk("R8 loaded vector in effect", pair_t, 12'h000);

        // R7: enable change during high phase is postponed
        to_low();
        pair_en = 12'hFFF;
        to_high();
        chk("R7 enabled before change", pair_t, 12'hFFF);
        pair_en = 12'h000;
        #1;
        chk("R7 high-phase change held off", pair_t, 12'hFFF);
        to_low();
        chk("R7 low phase quiet", pair_t, 12'h000);
        to_high();
        chk("R7 change applied next cycle", pair_t, 12'h000);
        pair_en = 12'hA5A;
        #1;
        chk("R7 re-enable held off", pair_t, 12'h000);
        to_high();
        chk("R7 re-enable applied", pair_t, 12'hA5A);

        // Exhaustive sweep over both modes and all enable patterns
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4096; p++) begin
                logic [11:0] pat;
                logic [11:0] sdrm;
                logic [11:0] exp_c;
                logic [11:0] exp_b;
                pat  = 12'(p);
                sdrm = (m == 1) ? 12'h000 : 12'h03F;
                to_low();
                ddr_only  = (m == 1);
                pair_en   = pat;
                sdr_boost = pat[0] ^ pat[7];
                ddr_boost = pat[3];
                #1;
                chk("R7 true legs low in low phase", pair_t, 12'h000);
                chk("R5 complement rest level", pair_c, ~sdrm);
                to_high();
                chk("R6 true legs follow enables", pair_t, pat);
                exp_c = (pat & sdrm) | (~pat & ~sdrm);
                chk((m == 1) ? "R3 complement legs" : "R4 complement legs", pair_c, exp_c);
                exp_b = ({12{sdr_boost}} & sdrm) | ({12{ddr_boost}} & ~sdrm);
                chk("R9 boost routing", pair_boost, exp_b);
                chk("R1 feedback high", {10'd0, fb_oe, fb_clk}, 12'h003);
            end
        end

        // R1: feedback runs even with all pairs disabled
        to_low();
        pair_en = 12'h000;
        chk("R1 feedback low phase", {10'd0, fb_oe, fb_clk}, 12'h002);
        to_high();
        chk("R1 feedback ungated", {10'd0, fb_oe, fb_clk}, 12'h003);

        // R2: power-down mid-run
        pd_n = 1'b0;
        #1;
        chk("R2 pair_oe dropped", pair_oe, 12'h000);
        chk("R2 fb_oe dropped", {11'd0, fb_oe}, 12'h000);
        to_high();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule